// File: doc/BRIEF.md
# Packet Timestamp Latch

This block records the value of a free-running 64-bit time base at the start of a time-synchronisation packet. The time is held in a pair of 32-bit holding words, and software polls a valid flag before it fetches the stored time. There are two independent slots, one for receive and one for transmit, and each slot has its own enable bit.

Each slot holds one timestamp only. Once it has captured, it locks, and later packets pass without a stamp. The slot stays locked until software reads its high holding word. That read is the only way to re-arm a slot, and it is also how software recovers a slot that was stamped for a packet that was later dropped.

A receive packet qualifies for a stamp according to a mode field. The field selects one of these:
- every packet;
- version-2 event messages carried in layer-2 frames, in UDP, or in either;
- one chosen version-1 message type carried in UDP.

An upstream parser supplies the classification fields that the mode field tests.

Top module: `pkt_ts_latch`

## Requirements
- R1: When a receive packet qualifies, the receive slot is enabled and its valid bit is clear, the time present at that packet's start edge is stored. Its low 32 bits appear at address 2 and its high 32 bits at address 3, and receive-valid (address 0, bit 4) reads 1 from the next cycle.
- R2: While a slot's valid bit is set, later qualifying packets leave both holding words and the valid bit unchanged.
- R3: A read of address 3 clears receive-valid from the next cycle. A read of address 2 alone leaves receive-valid set.
- R4: The transmit slot is controlled at address 4 (bit 0 enable, bit 4 valid, read-only). While it is enabled and not valid, every transmit start captures the time into address 5 (low word) and address 6 (high word). A read of address 6 clears the transmit valid bit.
- R5: A slot whose enable bit is 0 captures nothing. Clearing the enable bit does not clear a pending valid bit or the stored time.
- R6: Receive control is at address 0: bit 0 is the enable and bits 3:1 are the mode. Mode 0 stamps every receive packet.
- R7: A packet is a layer-2 match when its ethertype is 0x88F7 and the layer-2 filter enable (address 1, bit 8) is 1. Mode 1 stamps layer-2 matches with version 2 and a message type of 0 to 3.
- R8: A packet is a layer-4 match when it is UDP with destination port 319 and, if the source-check bit (address 1, bit 9) is 1, also has source port 319. Mode 2 stamps version-2 layer-4 matches with a message type of 0 to 3. Mode 3 stamps version-2 packets with a message type of 0 to 3 that are a layer-2 or a layer-4 match.
- R9: Mode 4 stamps layer-4 matches with version 1 whose message type equals address 1, bits 3:0.
- R10: After reset, all holding words, both valid bits, both enables and all configuration fields read 0.
- R11: Modes 5 to 7 stamp no packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| time_now | input | 64 | Current time base value |
| rx_start | input | 1 | One-cycle strobe at the start of a received packet |
| rx_ethertype | input | 16 | Ethertype of the received packet |
| rx_is_udp | input | 1 | The received packet is UDP |
| rx_dst_port | input | 16 | UDP destination port |
| rx_src_port | input | 16 | UDP source port |
| rx_version | input | 4 | Time-sync protocol version field |
| rx_msg_type | input | 4 | Time-sync message type field |
| tx_start | input | 1 | One-cycle strobe at the start of a transmit packet marked for stamping |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives the read side effects) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, a combinational function of reg_addr |

## Verification
The bench aims at the lock edge cases:
- A second packet arriving right after a capture. A design that does not lock would return the second time.
- A low-word read. A design that unlocks on it would stamp the next packet early.
- Disabling a slot while it holds a stamp. A design that clears on disable would lose the pending time.

The classifier is probed one condition at a time: wrong ethertype, layer-2 filter off, source check on, version-1 message type mismatch and a reserved mode. A faulty qualifier would show up as a set or missing valid bit. The capture time is also checked across a carry into the high word, which exposes a capture taken one cycle late or an order swap between the two halves.

// File: rtl/ts_latch_pkg.sv
package ts_latch_pkg;

    localparam int unsigned ADDR_W = 3;

    // Register addresses
    localparam logic [ADDR_W-1:0] A_RX_CTL = 3'd0;
    localparam logic [ADDR_W-1:0] A_RX_CFG = 3'd1;
    localparam logic [ADDR_W-1:0] A_RX_LO  = 3'd2;
    localparam logic [ADDR_W-1:0] A_RX_HI  = 3'd3;
    localparam logic [ADDR_W-1:0] A_TX_CTL = 3'd4;
    localparam logic [ADDR_W-1:0] A_TX_LO  = 3'd5;
    localparam logic [ADDR_W-1:0] A_TX_HI  = 3'd6;

    // Receive qualification modes
    localparam logic [2:0] M_ALL    = 3'd0;
    localparam logic [2:0] M_V2_L2  = 3'd1;
    localparam logic [2:0] M_V2_L4  = 3'd2;
    localparam logic [2:0] M_V2_ANY = 3'd3;
    localparam logic [2:0] M_V1_L4  = 3'd4;

    localparam logic [15:0] SYNC_ETHERTYPE = 16'h88F7;
    localparam logic [15:0] SYNC_EVT_PORT  = 16'd319;

    typedef struct packed {
        logic [15:0] ethertype;
        logic        is_udp;
        logic [15:0] dst_port;
        logic [15:0] src_port;
        logic [3:0]  version;
        logic [3:0]  msg_type;
    } rx_pkt_t;

    typedef struct packed {
        logic       en;
        logic [2:0] mode;
        logic [3:0] v1_msg;
        logic       l2_en;
        logic       src_chk;
    } rx_cfg_t;

endpackage

// File: rtl/ts_rx_qualify.sv
// Decides whether a received packet should be stamped.
// Assumes the classification fields are valid in the cycle of rx_start.
module ts_rx_qualify
    import ts_latch_pkg::*;
(
    input  rx_pkt_t pkt,
    input  rx_cfg_t cfg,
    output logic    qualify
);
    logic l2_hit, l4_hit, v2_evt, v1_sel;

    // Transport-level and message-level matches.
    always_comb begin
        l2_hit = cfg.l2_en && (pkt.ethertype == SYNC_ETHERTYPE);
        l4_hit = pkt.is_udp && (pkt.dst_port == SYNC_EVT_PORT) &&
                 (!cfg.src_chk || (pkt.src_port == SYNC_EVT_PORT));
        v2_evt = (pkt.version == 4'd2) && (pkt.msg_type < 4'd4);
        v1_sel = (pkt.version == 4'd1) && (pkt.msg_type == cfg.v1_msg);
    end

    // Mode selection; reserved modes match nothing.
    always_comb begin
        unique case (cfg.mode)
            M_ALL:    qualify = 1'b1;
            M_V2_L2:  qualify = v2_evt && l2_hit;
            M_V2_L4:  qualify = v2_evt && l4_hit;
            M_V2_ANY: qualify = v2_evt && (l2_hit || l4_hit);
            M_V1_L4:  qualify = v1_sel && l4_hit;
            default:  qualify = 1'b0;
        endcase
    end
endmodule

// File: rtl/ts_slot.sv
// One lockable timestamp slot: captures on hit while enabled and empty,
// releases only on clr. Assumes hit and clr are one-cycle strobes.
module ts_slot #(
    parameter int unsigned TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              hit,
    input  logic              clr,
    input  logic [TIME_W-1:0] time_now,
    output logic              valid,
    output logic [TIME_W-1:0] stamp
);
    // Capture-and-lock state; capture has priority only when empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            stamp <= '0;
        end else if (en && hit && !valid) begin
            valid <= 1'b1;
            stamp <= time_now;
        end else if (clr) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/ts_regs.sv
// Configuration registers, read mux and read-side unlock strobes.
// Assumes reg_rd is asserted for one cycle per software read.
module ts_regs
    import ts_latch_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    localparam int unsigned TIME_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic              rx_valid,
    input  logic [TIME_W-1:0] rx_stamp,
    input  logic              tx_valid,
    input  logic [TIME_W-1:0] tx_stamp,
    output rx_cfg_t           rx_cfg,
    output logic              tx_en,
    output logic              rx_clr,
    output logic              tx_clr,
    output logic [WORD_W-1:0] reg_rdata
);
    // Software-written configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_cfg <= '0;
            tx_en  <= 1'b0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_RX_CTL: begin
                    rx_cfg.en   <= reg_wdata[0];
                    rx_cfg.mode <= reg_wdata[3:1];
                end
                A_RX_CFG: begin
                    rx_cfg.v1_msg  <= reg_wdata[3:0];
                    rx_cfg.l2_en   <= reg_wdata[8];
                    rx_cfg.src_chk <= reg_wdata[9];
                end
                A_TX_CTL: tx_en <= reg_wdata[0];
                default: ;
            endcase
        end
    end

    // High-word reads are the unlock events.
    always_comb begin
        rx_clr = reg_rd && (reg_addr == A_RX_HI);
        tx_clr = reg_rd && (reg_addr == A_TX_HI);
    end

    // Read data mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_RX_CTL: begin
                reg_rdata[0]   = rx_cfg.en;
                reg_rdata[3:1] = rx_cfg.mode;
                reg_rdata[4]   = rx_valid;
            end
            A_RX_CFG: begin
                reg_rdata[3:0] = rx_cfg.v1_msg;
                reg_rdata[8]   = rx_cfg.l2_en;
                reg_rdata[9]   = rx_cfg.src_chk;
            end
            A_RX_LO:  reg_rdata = rx_stamp[WORD_W-1:0];
            A_RX_HI:  reg_rdata = rx_stamp[TIME_W-1:WORD_W];
            A_TX_CTL: begin
                reg_rdata[0] = tx_en;
                reg_rdata[4] = tx_valid;
            end
            A_TX_LO:  reg_rdata = tx_stamp[WORD_W-1:0];
            A_TX_HI:  reg_rdata = tx_stamp[TIME_W-1:WORD_W];
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pkt_ts_latch.sv
// Packet timestamp latch top: receive and transmit lockable slots,
// receive qualification and register access. Assumes time_now is
// synchronous to clk.
module pkt_ts_latch
    import ts_latch_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*WORD_W-1:0] time_now,
    input  logic                rx_start,
    input  logic [15:0]         rx_ethertype,
    input  logic                rx_is_udp,
    input  logic [15:0]         rx_dst_port,
    input  logic [15:0]         rx_src_port,
    input  logic [3:0]          rx_version,
    input  logic [3:0]          rx_msg_type,
    input  logic                tx_start,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [2:0]          reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata
);
    localparam int unsigned TIME_W = 2 * WORD_W;
    localparam int unsigned NSLOT  = 2;   // index 0 receive, 1 transmit

    rx_pkt_t           pkt;
    rx_cfg_t           rx_cfg;
    logic              rx_qual, tx_en, rx_clr, tx_clr;
    logic [NSLOT-1:0]  s_en, s_hit, s_clr, s_valid;
    logic [TIME_W-1:0] s_stamp [NSLOT];

    // Bundle parser fields.
    always_comb begin
        pkt = '{ethertype: rx_ethertype, is_udp: rx_is_udp,
                dst_port: rx_dst_port, src_port: rx_src_port,
                version: rx_version, msg_type: rx_msg_type};
    end

    ts_rx_qualify u_qual (
        .pkt     (pkt),
        .cfg     (rx_cfg),
        .qualify (rx_qual)
    );

    // Per-slot control routing.
    always_comb begin
        s_en  = {tx_en, rx_cfg.en};
        s_hit = {tx_start, rx_start && rx_qual};
        s_clr = {tx_clr, rx_clr};
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        ts_slot #(.TIME_W(TIME_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (s_en[g]),
            .hit      (s_hit[g]),
            .clr      (s_clr[g]),
            .time_now (time_now),
            .valid    (s_valid[g]),
            .stamp    (s_stamp[g])
        );
    end

    ts_regs #(.WORD_W(WORD_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .rx_valid  (s_valid[0]),
        .rx_stamp  (s_stamp[0]),
        .tx_valid  (s_valid[1]),
        .tx_stamp  (s_stamp[1]),
        .rx_cfg    (rx_cfg),
        .tx_en     (tx_en),
        .rx_clr    (rx_clr),
        .tx_clr    (tx_clr),
        .reg_rdata (reg_rdata)
    );
endmodule

// File: rtl/pkt_ts_latch_chk.sv
// Property checker for pkt_ts_latch, attached by bind.
module pkt_ts_latch_chk #(
    parameter int unsigned TIME_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TIME_W-1:0] time_now,
    input logic              rx_valid,
    input logic [TIME_W-1:0] rx_stamp,
    input logic              rx_clr,
    input logic              rx_hit,
    input logic              rx_en,
    input logic              tx_valid,
    input logic [TIME_W-1:0] tx_stamp,
    input logic              tx_clr,
    input logic              tx_start,
    input logic              tx_en
);
    logic past_ok;

    // Marks cycles whose previous sample lies after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r1_rx_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && rx_hit && !rx_valid) |=> (rx_valid && rx_stamp == $past(time_now)));

    a_r2_rx_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(rx_valid) && !$past(rx_clr)) |->
        (rx_valid && rx_stamp == $past(rx_stamp)));

    a_r3_rx_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clr |=> !rx_valid);

    a_r4_tx_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && tx_start && !tx_valid) |=> (tx_valid && tx_stamp == $past(time_now)));

    a_r4_tx_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clr |=> !tx_valid);

    a_r5_rx_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !rx_valid) |=> !rx_valid);
endmodule

bind pkt_ts_latch pkt_ts_latch_chk #(.TIME_W(2 * WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .time_now (time_now),
    .rx_valid (s_valid[0]),
    .rx_stamp (s_stamp[0]),
    .rx_clr   (rx_clr),
    .rx_hit   (s_hit[0]),
    .rx_en    (s_en[0]),
    .tx_valid (s_valid[1]),
    .tx_stamp (s_stamp[1]),
    .tx_clr   (tx_clr),
    .tx_start (tx_start),
    .tx_en    (s_en[1])
);

// File: tb/test_pkt_ts_latch.sv
module test_pkt_ts_latch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] time_now = 64'h0000_0004_FFFF_FFF0;
    logic        rx_start = 0, rx_is_udp = 0, tx_start = 0;
    logic [15:0] rx_ethertype = 0, rx_dst_port = 0, rx_src_port = 0;
    logic [3:0]  rx_version = 0, rx_msg_type = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [2:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;

    int checks = 0, errors = 0;

    // Model state
    logic        m_rx_en = 0, m_l2 = 0, m_src = 0, m_tx_en = 0;
    logic [2:0]  m_mode = 0;
    logic [3:0]  m_v1 = 0;
    logic        m_rx_v = 0, m_tx_v = 0;
    logic [63:0] m_rx_t = 0, m_tx_t = 0;

    pkt_ts_latch i_pkt_ts_latch (
        .clk(clk), .rst_n(rst_n), .time_now(time_now),
        .rx_start(rx_start), .rx_ethertype(rx_ethertype), .rx_is_udp(rx_is_udp),
        .rx_dst_port(rx_dst_port), .rx_src_port(rx_src_port),
        .rx_version(rx_version), .rx_msg_type(rx_msg_type),
        .tx_start(tx_start), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always #10 clk = ~clk;                       // 50 MHz
    always @(negedge clk) time_now <= time_now + 64'd1;

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic logic qual(input logic [15:0] et, input logic udp,
                                  input logic [15:0] dp, input logic [15:0] sp,
                                  input logic [3:0] ver, input logic [3:0] msg);
        logic l2, l4, v2e;
        l2  = m_l2 && et == 16'h88F7;
        l4  = udp && dp == 16'd319 && (!m_src || sp == 16'd319);
        v2e = ver == 4'd2 && msg <= 4'd3;
        case (m_mode)
            3'd0: return 1'b1;
            3'd1: return v2e && l2;
            3'd2: return v2e && l4;
            3'd3: return v2e && (l2 || l4);
            3'd4: return ver == 4'd1 && msg == m_v1 && l4;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] exp_reg(input logic [2:0] a);
        case (a)
            3'd0: return {27'd0, m_rx_v, m_mode, m_rx_en};
            3'd1: return {22'd0, m_src, m_l2, 4'd0, m_v1};
            3'd2: return m_rx_t[31:0];
            3'd3: return m_rx_t[63:32];
            3'd4: return {27'd0, m_tx_v, 3'd0, m_tx_en};
            3'd5: return m_tx_t[31:0];
            3'd6: return m_tx_t[63:32];
            default: return 32'd0;
        endcase
    endfunction

    // All tasks start and end just after a falling edge.
    task automatic rd(input logic [2:0] a, input string tag);
        logic [31:0] e;
        reg_rd = 1; reg_addr = a;
        #1;
        e = exp_reg(a);
        checks++;
        if (reg_rdata !== e) begin
            errors++;
            $display("FAIL %s addr %0d: actual %h expected %h", tag, a, reg_rdata, e);
        end
        @(negedge clk);
        reg_rd = 0;
        if (a == 3'd3) m_rx_v = 0;
        if (a == 3'd6) m_tx_v = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
        if (a == 3'd0) begin m_rx_en = d[0]; m_mode = d[3:1]; end
        if (a == 3'd1) begin m_v1 = d[3:0]; m_l2 = d[8]; m_src = d[9]; end
        if (a == 3'd4) m_tx_en = d[0];
    endtask

    task automatic rxp(input logic [15:0] et, input logic udp, input logic [15:0] dp,
                       input logic [15:0] sp, input logic [3:0] ver, input logic [3:0] msg);
        rx_ethertype = et; rx_is_udp = udp; rx_dst_port = dp;
        rx_src_port = sp; rx_version = ver; rx_msg_type = msg; rx_start = 1;
        #1;
        if (m_rx_en && !m_rx_v && qual(et, udp, dp, sp, ver, msg)) begin
            m_rx_v = 1; m_rx_t = time_now;
        end
        @(negedge clk);
        rx_start = 0;
    endtask

    task automatic txp();
        tx_start = 1;
        #1;
        if (m_tx_en && !m_tx_v) begin m_tx_v = 1; m_tx_t = time_now; end
        @(negedge clk);
        tx_start = 0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state
        for (int a = 0; a < 7; a++) rd(a[2:0], "R10");
        // R5 disabled receive slot
        rxp(16'h88F7, 1, 319, 319, 2, 0);
        rd(0, "R5");
        // R6 mode all, R1 capture across high-word carry, R3 low read keeps lock
        wr(0, 32'h1);
        rxp(16'h0800, 0, 0, 0, 0, 9);
        rd(0, "R1");
        rd(2, "R1");
        rd(0, "R3");
        rxp(16'h0800, 0, 0, 0, 0, 9);              // R2 second packet ignored
        rd(2, "R2");
        rd(3, "R1");
        rd(0, "R3");
        // R2 back-to-back packets
        rxp(16'h1234, 0, 0, 0, 0, 0);
        rxp(16'h1234, 0, 0, 0, 0, 0);
        rd(2, "R2"); rd(3, "R2");
        // R5 disabling keeps pending stamp
        rxp(16'h1, 0, 0, 0, 0, 0);
        wr(0, 32'h0);
        rd(0, "R5"); rd(2, "R5"); rd(3, "R5");
        // R7 layer-2 version-2 events
        wr(0, {28'd0, 3'd1, 1'b1});
        rxp(16'h88F7, 0, 0, 0, 2, 1);              // filter off: none
        rd(0, "R7");
        wr(1, 32'h100);
        rxp(16'h88F7, 0, 0, 0, 2, 8);              // not an event: none
        rd(0, "R7");
        rxp(16'h88F7, 0, 0, 0, 2, 3);
        rd(0, "R7"); rd(3, "R7");
        // R8 layer-4 with and without source check
        wr(0, {28'd0, 3'd2, 1'b1});
        rxp(16'h0800, 1, 319, 777, 2, 0);
        rd(0, "R8"); rd(3, "R8");
        wr(1, 32'h200);
        rxp(16'h0800, 1, 319, 777, 2, 0);
        rd(0, "R8");
        rxp(16'h0800, 1, 319, 319, 2, 1);
        rd(0, "R8"); rd(3, "R8");
        // R9 version-1 selected message type
        wr(1, 32'h001);
        wr(0, {28'd0, 3'd4, 1'b1});
        rxp(16'h0800, 1, 319, 0, 1, 0);
        rd(0, "R9");
        rxp(16'h0800, 1, 319, 0, 1, 1);
        rd(0, "R9"); rd(3, "R9");
        // R11 reserved mode
        wr(0, {28'd0, 3'd6, 1'b1});
        rxp(16'h88F7, 1, 319, 319, 2, 0);
        rd(0, "R11");
        // R4 transmit slot
        txp();
        rd(4, "R4");
        wr(4, 32'h1);
        txp(); txp();
        rd(4, "R4"); rd(5, "R4"); rd(6, "R4"); rd(4, "R4");
        // Random mix, R1 R2 R3 R4 checked against model
        for (int i = 0; i < 3000; i++) begin
            int op = $urandom % 10;
            case (op)
                0, 1, 2, 3: rxp(($urandom % 2) ? 16'h88F7 : 16'($urandom),
                                1'($urandom), ($urandom % 2) ? 16'd319 : 16'($urandom),
                                ($urandom % 2) ? 16'd319 : 16'($urandom),
                                4'($urandom % 3), 4'($urandom % 5));
                4: txp();
                5: rd(0, "R1");
                6: rd(2, "R3");
                7: rd(3, "R3");
                8: rd(3'd4 + 3'($urandom % 3), "R4");
                default: begin
                    if ($urandom % 2) wr(0, {28'd0, 3'($urandom % 8), 1'($urandom % 4 != 0)});
                    else if ($urandom % 2) wr(1, {22'd0, 2'($urandom), 4'd0, 4'($urandom % 3)});
                    else wr(4, {31'd0, 1'($urandom)});
                end
            endcase
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule